// File: doc/BRIEF.md
# Radix-2^v Word-Serial Montgomery Multiplier

This block computes a Montgomery product one machine word at a time. It takes a V-bit digit of the multiplier X in each outer step, so an N-bit operand needs only N/V + 1 steps instead of N. The caller supplies a modified modulus, mt, computed ahead of time from the real modulus M. It is formed by taking the inverse of -M modulo 2^V (call it k), forming k·M, adding one and dividing by 2^V. The quotient digit of each step is then just the low V bits of the running sum Z, with no multiplication. The digit product X_i·Y and the correction q·mt are added in the same word pass, together with Z shifted down by V bits.

Operands stay in the caller's memories. The block drives a digit index and a word index, and it samples the digit and the two operand words in the same cycle, so the caller's read path must be combinational. A one-cycle start pulse begins a product. The result is held in an internal register file and then streamed out one word per cycle, least significant word first. A done pulse marks the last word. No final subtraction is performed, so the result can exceed M. The outer loop runs one step more than the digit count, and that extra step uses a zero digit.

Top module: `hrmont_mul`

## Requirements
- R1: While reset is high and in the cycle after it, busy, z_valid and done are all 0.
- R2: The words streamed out equal the value of the following loop, run for i = 0 to F with F = N/V and Z starting at 0. In each step, q = Z mod 2^V, and Z becomes floor(Z / 2^V) + q·mt + X_i·Y, where X_i is bits [V·i+V-1 : V·i] of X.
- R3: For an odd modulus M with k·M ≡ -1 (mod 2^V) and mt = (k·M + 1) / 2^V, the result Z satisfies Z·2^N ≡ X·Y (mod M).
- R4: The result is below 2^(N+V+1). Every bit of the top output word at or above bit position N+V+1-(NW-1)·W reads 0, where NW = ceil((N+V+1)/W).
- R5: A product makes F+1 outer steps. dig_idx goes from 0 to F and never moves backwards while busy. The x_digit value presented while dig_idx = F is ignored and treated as zero.
- R6: done is high in the cycle that follows (F+1)·NW + NW - 1 rising edges after the edge that accepts start. With the default parameters this is 49 edges.
- R7: The result comes out as NW consecutive cycles with z_valid high. z_idx runs 0, 1, …, NW-1 in that order, and done is high only together with the word at z_idx = NW-1.
- R8: A start that arrives while busy is high is ignored, and this includes the cycle in which done is high. Such a start does not change the result, and busy is 0 in the cycle after done.
- R9: The y_word and mt_word values presented while opnd_idx ≥ N/W are ignored and treated as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a product while idle |
| busy | output | 1 | High from the accepted start through the last output word |
| dig_idx | output | $clog2(N/V+1) | Index of the X digit being requested |
| x_digit | input | V | X digit at dig_idx, read in the same cycle |
| opnd_idx | output | $clog2(NW) | Index of the Y and mt words being requested |
| y_word | input | W | Y word at opnd_idx |
| mt_word | input | W | Modified-modulus word at opnd_idx |
| z_valid | output | 1 | A result word is present on z_word |
| z_idx | output | $clog2(NW) | Index of the word on z_word |
| z_word | output | W | Result word |
| done | output | 1 | High with the last result word |

## Verification
Two events can fall in the same cycle: the block finishing a product (done high with the last word) and a new start request. The bench raises start in exactly the done cycle and also once in the middle of a computation. It then checks that the running result is still correct word for word, that busy drops in the following cycle and that no extra words appear. The extra zero-digit step is also exercised on every product, because the bench leaves random garbage in the digit slot F and in the operand words above N/W.

// File: rtl/hrmont_pkg.sv
package hrmont_pkg;

    // Control phase of the multiplier
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CALC = 2'd1,
        PH_EMIT = 2'd2
    } phase_t;

    // Rounded-up division for word counts
    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

endpackage

// File: rtl/hrmont_seq.sv
module hrmont_seq
    import hrmont_pkg::*;
#(
    parameter int F     = 8,
    parameter int NW    = 5,
    parameter int DIGW  = 4,
    parameter int WIDXW = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output phase_t           phase,
    output logic [DIGW-1:0]  dig,
    output logic [WIDXW-1:0] wrd,
    output logic             launch,
    output logic             calc,
    output logic             emit,
    output logic             last_dig,
    output logic             done
);
    localparam logic [WIDXW-1:0] WLAST = WIDXW'(NW - 1);
    localparam logic [DIGW-1:0]  DLAST = DIGW'(F);

    logic wrap;

    assign launch   = (phase == PH_IDLE) && start;
    assign calc     = (phase == PH_CALC);
    assign emit     = (phase == PH_EMIT);
    assign wrap     = (wrd == WLAST);
    assign last_dig = (dig == DLAST);
    assign done     = emit && wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            dig   <= '0;
            wrd   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_CALC;
                        dig   <= '0;
                        wrd   <= '0;
                    end
                end
                PH_CALC: begin
                    if (wrap) begin
                        wrd <= '0;
                        if (last_dig) phase <= PH_EMIT;
                        else          dig   <= dig + 1'b1;
                    end else begin
                        wrd <= wrd + 1'b1;
                    end
                end
                PH_EMIT: begin
                    if (wrap) begin
                        wrd   <= '0;
                        phase <= PH_IDLE;
                    end else begin
                        wrd <= wrd + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hrmont_zfile.sv
module hrmont_zfile #(
    parameter int W     = 16,
    parameter int V     = 8,
    parameter int NW    = 5,
    parameter int WIDXW = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             we,
    input  logic [WIDXW-1:0] widx,
    input  logic [W-1:0]     wdata,
    input  logic [WIDXW-1:0] sidx,
    output logic [W-1:0]     sdata,
    input  logic [WIDXW-1:0] ridx,
    output logic [W-1:0]     rdata,
    output logic [V-1:0]     low_digit
);
    logic [W-1:0] zr [NW];
    logic [W-1:0] sh [NW];

    // Word j of Z shifted down by V bits, built from words j and j+1
    for (genvar j = 0; j < NW; j++) begin : g_shift
        if (V == W) begin : g_full
            if (j == NW - 1) begin : g_top
                assign sh[j] = '0;
            end else begin : g_mid
                assign sh[j] = zr[j+1];
            end
        end else begin : g_part
            if (j == NW - 1) begin : g_top
                assign sh[j] = {{V{1'b0}}, zr[j][W-1:V]};
            end else begin : g_mid
                assign sh[j] = {zr[j+1][V-1:0], zr[j][W-1:V]};
            end
        end
    end

    assign sdata     = sh[sidx];
    assign rdata     = zr[ridx];
    assign low_digit = zr[0][V-1:0];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int k = 0; k < NW; k++) zr[k] <= '0;
        end else if (we) begin
            zr[widx] <= wdata;
        end
    end
endmodule

// File: rtl/hrmont_mac.sv
module hrmont_mac #(
    parameter int W = 16,
    parameter int V = 8
) (
    input  logic [V-1:0]   q,
    input  logic [V-1:0]   xd,
    input  logic [W-1:0]   mt,
    input  logic [W-1:0]   yw,
    input  logic [W-1:0]   zs,
    input  logic [V:0]     cin,
    output logic [V+W:0]   sum
);
    localparam int PW = V + W;
    localparam int SW = V + W + 1;

    logic [PW-1:0] p_red;
    logic [PW-1:0] p_dig;

    // Two V x W products summed with the shifted word and the carry
    assign p_red = PW'(q)  * PW'(mt);
    assign p_dig = PW'(xd) * PW'(yw);
    assign sum   = SW'(p_red) + SW'(p_dig) + SW'(zs) + SW'(cin);
endmodule

// File: rtl/hrmont_mul.sv
module hrmont_mul
    import hrmont_pkg::*;
#(
    parameter int N = 64,
    parameter int W = 16,
    parameter int V = 8,
    localparam int F     = N / V,
    localparam int E     = N / W,
    localparam int NW    = ceil_div(N + V + 1, W),
    localparam int DIGW  = $clog2(F + 1),
    localparam int WIDXW = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic [DIGW-1:0]  dig_idx,
    input  logic [V-1:0]     x_digit,
    output logic [WIDXW-1:0] opnd_idx,
    input  logic [W-1:0]     y_word,
    input  logic [W-1:0]     mt_word,
    output logic             z_valid,
    output logic [WIDXW-1:0] z_idx,
    output logic [W-1:0]     z_word,
    output logic             done
);
    localparam logic [WIDXW-1:0] OPLAST = WIDXW'(E - 1);

    phase_t           phase;
    logic [DIGW-1:0]  dig;
    logic [WIDXW-1:0] wrd;
    logic             launch, calc, emit, last_dig;
    logic             first;
    logic [V-1:0]     q_reg, q_now, zlow, x_now;
    logic [V:0]       c_reg, cin;
    logic [W-1:0]     y_eff, m_eff, zs, rdata;
    logic [V+W:0]     sum;

    hrmont_seq #(.F(F), .NW(NW), .DIGW(DIGW), .WIDXW(WIDXW)) u_seq (
        .clk(clk), .rst(rst), .start(start), .phase(phase),
        .dig(dig), .wrd(wrd), .launch(launch), .calc(calc),
        .emit(emit), .last_dig(last_dig), .done(done)
    );

    hrmont_zfile #(.W(W), .V(V), .NW(NW), .WIDXW(WIDXW)) u_zfile (
        .clk(clk), .rst(rst), .clr(launch), .we(calc),
        .widx(wrd), .wdata(sum[W-1:0]), .sidx(wrd), .sdata(zs),
        .ridx(wrd), .rdata(rdata), .low_digit(zlow)
    );

    // Quotient digit is taken from word 0 before that word is rewritten
    assign first = (wrd == '0);
    assign q_now = first ? zlow : q_reg;
    assign cin   = first ? '0 : c_reg;
    // The extra step of the prescaled loop uses a zero digit
    assign x_now = last_dig ? '0 : x_digit;
    // Operand words above the N-bit range read as zero
    assign y_eff = (wrd <= OPLAST) ? y_word  : '0;
    assign m_eff = (wrd <= OPLAST) ? mt_word : '0;

    hrmont_mac #(.W(W), .V(V)) u_mac (
        .q(q_now), .xd(x_now), .mt(m_eff), .yw(y_eff),
        .zs(zs), .cin(cin), .sum(sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q_reg <= '0;
            c_reg <= '0;
        end else if (calc) begin
            if (first) q_reg <= zlow;
            c_reg <= sum[V+W:W];
        end
    end

    assign busy     = (phase != PH_IDLE);
    assign dig_idx  = dig;
    assign opnd_idx = wrd;
    assign z_valid  = emit;
    assign z_idx    = wrd;
    assign z_word   = rdata;
endmodule

// File: rtl/hrmont_chk.sv
module hrmont_chk #(
    parameter int N     = 64,
    parameter int W     = 16,
    parameter int V     = 8,
    parameter int NW    = 5,
    parameter int DIGW  = 4,
    parameter int WIDXW = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic [DIGW-1:0]  dig_idx,
    input logic             z_valid,
    input logic [WIDXW-1:0] z_idx,
    input logic [W-1:0]     z_word,
    input logic             done
);
    localparam int TOPB = N + V + 1 - (NW - 1) * W;
    localparam logic [WIDXW-1:0] ZLAST = WIDXW'(NW - 1);

    // R7
    done_last_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (z_valid && z_idx == ZLAST));

    // R7
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (z_valid && !done) |=> (z_valid && z_idx == $past(z_idx) + 1'b1));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!z_valid && !done));

    // R8
    done_release_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R5
    dig_step_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || dig_idx == $past(dig_idx) || dig_idx == $past(dig_idx) + 1'b1));

    if (TOPB < W) begin : g_top
        // R4
        top_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (z_valid && z_idx == ZLAST) |-> (z_word[W-1:TOPB] == '0));
    end
endmodule

bind hrmont_mul hrmont_chk #(
    .N(N), .W(W), .V(V), .NW(NW), .DIGW(DIGW), .WIDXW(WIDXW)
) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .dig_idx(dig_idx),
    .z_valid(z_valid), .z_idx(z_idx), .z_word(z_word), .done(done)
);

// File: tb/hrmont_mul_bench.sv
`timescale 1ns/1ps
module hrmont_mul_bench;
    localparam int N     = 64;
    localparam int W     = 16;
    localparam int V     = 8;
    localparam int F     = N / V;
    localparam int E     = N / W;
    localparam int NW    = (N + V + 1 + W - 1) / W;
    localparam int DIGW  = $clog2(F + 1);
    localparam int WIDXW = $clog2(NW);
    localparam int LAT   = (F + 1) * NW + NW - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    always #2 clk = ~clk;

    logic             busy, z_valid, done;
    logic [DIGW-1:0]  dig_idx;
    logic [WIDXW-1:0] opnd_idx, z_idx;
    logic [V-1:0]     x_digit;
    logic [W-1:0]     y_word, mt_word, z_word;

    logic [V-1:0] xmem [F+1];
    logic [W-1:0] ymem [NW];
    logic [W-1:0] mmem [NW];

    assign x_digit = xmem[dig_idx];
    assign y_word  = ymem[opnd_idx];
    assign mt_word = mmem[opnd_idx];

    hrmont_mul #(.N(N), .W(W), .V(V)) u_hrmont_mul (
        .clk(clk), .rst(rst), .start(start), .busy(busy),
        .dig_idx(dig_idx), .x_digit(x_digit), .opnd_idx(opnd_idx),
        .y_word(y_word), .mt_word(mt_word), .z_valid(z_valid),
        .z_idx(z_idx), .z_word(z_word), .done(done)
    );

    int vecs = 0;
    int fails = 0;
    int ndone = 0;
    int cyc = 0;
    int t0 = 0;
    int exp_idx = 0;
    logic [W-1:0]   exp_q [$];
    logic [255:0]   jx_q [$];
    logic [255:0]   jy_q [$];
    logic [255:0]   jm_q [$];
    logic [255:0]   acc = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag,
                       input logic [255:0] act, input logic [255:0] exp);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected words and judges each finished product
    always @(negedge clk) begin
        if (!rst && z_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 R8 unexpected word", 256'(z_word), '0);
            end else begin
                logic [W-1:0] ew;
                ew = exp_q.pop_front();
                chk(z_word == ew, "R2 R5 R7 word", 256'(z_word), 256'(ew));
                chk(int'(z_idx) == exp_idx, "R7 index", 256'(z_idx), 256'(exp_idx));
                acc = acc | (256'(z_word) << (W * exp_idx));
                exp_idx++;
            end
            if (done) begin
                logic [255:0] jx, jy, jm;
                jx = jx_q.pop_front();
                jy = jy_q.pop_front();
                jm = jm_q.pop_front();
                chk(cyc - t0 == LAT, "R6 latency", 256'(cyc - t0), 256'(LAT));
                chk((acc >> (N + V + 1)) == '0, "R4 bound", acc, '0);
                chk(((acc << N) % jm) == ((jx * jy) % jm), "R3 R9 congruence",
                    (acc << N) % jm, (jx * jy) % jm);
                acc = '0;
                exp_idx = 0;
                ndone++;
            end
        end
    end

    // Driver: loads operand memories, pushes the expected result, starts
    task automatic run_job(input logic [63:0] xv, input logic [63:0] yv,
                           input logic [63:0] mv, input bit mid, input bit tail);
        logic [255:0] kk, mfull, mt, z, q, xi;
        int target;
        kk = '0;
        for (int k = 1; k < 256; k++)
            if (((256'(k) * 256'(mv)) & 256'hFF) == 256'hFF) kk = 256'(k);
        mfull = kk * 256'(mv);
        mt = (mfull + 1) >> V;
        for (int i = 0; i < F; i++) xmem[i] = xv[i*V +: V];
        xmem[F] = V'($urandom);            // R5: garbage in the extra digit slot
        for (int j = 0; j < NW; j++) begin
            if (j < E) begin
                ymem[j] = yv[j*W +: W];
                mmem[j] = mt[j*W +: W];
            end else begin                 // R9: garbage above the operand range
                ymem[j] = W'($urandom);
                mmem[j] = W'($urandom);
            end
        end
        z = '0;
        for (int i = 0; i <= F; i++) begin
            q  = z & 256'hFF;
            xi = (i < F) ? ((256'(xv) >> (i * V)) & 256'hFF) : '0;
            z  = (z >> V) + q * mt + xi * 256'(yv);
        end
        for (int j = 0; j < NW; j++) exp_q.push_back(z[j*W +: W]);
        jx_q.push_back(256'(xv));
        jy_q.push_back(256'(yv));
        jm_q.push_back(256'(mv));
        target = ndone + 1;
        @(negedge clk) start = 1'b1;
        @(posedge clk) #1 t0 = cyc;
        @(negedge clk) start = 1'b0;
        if (mid) begin                     // R8: start while busy
            repeat (10) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        if (tail) begin                    // R8: start in the done cycle
            while (!done) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
            chk(busy == 1'b0, "R8 busy after done", 256'(busy), '0);
        end
        while (ndone != target) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && exp_q.size() == 0, "R8 idle after product",
            256'(busy), '0);
    endtask

    function automatic logic [63:0] rnd_mod();
        logic [63:0] m;
        m = {$urandom, $urandom};
        m[63] = 1'b1;
        m[0]  = 1'b1;
        return m;
    endfunction

    initial begin
        for (int i = 0; i <= F; i++) xmem[i] = '0;
        for (int j = 0; j < NW; j++) begin
            ymem[j] = '0;
            mmem[j] = '0;
        end
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R1 busy in reset", 256'(busy), '0);
        chk(z_valid == 1'b0, "R1 z_valid in reset", 256'(z_valid), '0);
        chk(done == 1'b0, "R1 done in reset", 256'(done), '0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && z_valid == 1'b0, "R1 after reset", 256'(busy), '0);

        run_job(64'd0, {$urandom, $urandom}, rnd_mod(), 1'b0, 1'b0);
        run_job({$urandom, $urandom}, 64'd0, rnd_mod(), 1'b0, 1'b0);
        run_job({64{1'b1}}, {64{1'b1}}, {64{1'b1}}, 1'b0, 1'b0);
        run_job({64{1'b1}}, {64{1'b1}}, 64'h8000_0000_0000_0001, 1'b0, 1'b0);
        for (int t = 0; t < 8; t++)
            run_job({$urandom, $urandom}, {$urandom, $urandom}, rnd_mod(), 1'b0, 1'b0);
        run_job({$urandom, $urandom}, {$urandom, $urandom}, rnd_mod(), 1'b1, 1'b0);
        run_job({$urandom, $urandom}, {$urandom, $urandom}, rnd_mod(), 1'b0, 1'b1);
        run_job({$urandom, $urandom}, {$urandom, $urandom}, rnd_mod(), 1'b1, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        vecs++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule